// File: doc/BRIEF.md
# Round-Robin Channel Refresh Sequencer

This block sits between the stored per-channel codes of a multi-output programmable voltage reference and its output stages. It visits the channels one at a time, in a fixed rotation. On each visit it moves the code applied to that channel's output stage toward the stored target code. No visit changes the applied code by more than a fixed step, so a large change spreads over several full rotations. A new target reaches its output within one slot at best. At worst it waits one whole rotation.

Visits happen on falling edges of a slow refresh clock. The clock comes either from an internal divider of the system clock, sized to a rate near 21 kHz, or from an external clock input that is synchronised into the system clock domain. A select input chooses between the two. In internal mode, and only when a build parameter allows it, the block drives its divided clock onto a shared synchronisation pin so that a second device can follow it. During reset and in external mode the pin driver stays off. Each visit raises a one-cycle refresh strobe that carries the number of the channel being serviced.

Top module: `gamma_refresh_seq`

## Requirements
- R1: During reset every applied code is 0, the refresh strobe is low and the clock-pin output enable is low.
- R2: With the select input low (internal source), successive refresh strobes are exactly 2*DIV_HALF system clock cycles apart.
- R3: Strobed channel numbers run 0, 1, ..., NUM_CH-1 and then wrap to 0. They are always below NUM_CH, and the rotation continues across changes of clock source.
- R4: The refresh strobe is high for exactly one system clock cycle per refresh.
- R5: An applied code changes only in the clock cycle right after a strobe that names its channel. All other channels keep their applied codes.
- R6: When the target and the applied code of the visited channel differ by at most MAX_STEP, the applied code becomes equal to the target.
- R7: When they differ by more than MAX_STEP, the applied code moves by exactly MAX_STEP toward the target, whether that is upward or downward. No applied code ever changes by more than MAX_STEP in one cycle.
- R8: With the select input high (external source), a strobe follows each high-to-low transition of the external clock input. It appears exactly 3 system clock cycles after the input changes. While the external input is held steady, no strobe occurs and the internal divider has no effect.
- R9: The clock-pin output enable is high only while the internal source is selected and DRIVE_PIN is 1. It follows the select input one cycle later. While it is enabled, the clock-pin output toggles every DIV_HALF cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| extSel | input | 1 | Clock source select: 1 = external input, 0 = internal divider |
| extClkIn | input | 1 | External refresh clock, asynchronous to clk |
| targetCodes | input | NUM_CH*CODE_W | Stored target code per channel; channel k is at bits k*CODE_W and upward |
| appliedCodes | output | NUM_CH*CODE_W | Code applied to each output stage, packed the same way |
| refreshStrobe | output | 1 | One-cycle pulse per refresh visit |
| refreshIdx | output | IDX_W | Channel serviced by the current strobe |
| oscOut | output | 1 | Internal divided clock for the shared pin |
| oscOe | output | 1 | Output enable for the shared clock pin |

## Verification
Small targets that lie within one step of the current codes show whether a visit lands the channel exactly on its target and leaves its neighbours untouched. Full-scale swings up and then back down separate a correct bounded step from an overshoot, a wrong direction or a stuck code, across several rotations. External-clock runs alternate long steady stretches with single falling edges. This tells a genuine edge detector with a 3-cycle latency apart from one that leaks internal ticks or fires on levels. Switching between the two sources shows that the channel rotation carries on and that the pin enable follows the select input.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  localparam int SLOT_W = 8;

  typedef struct packed {
    logic              load;
    logic [SLOT_W-1:0] slot;
  } refresh_ctl_t;
endpackage

// File: rtl/refresh_ctrl.sv
module refresh_ctrl
  import refresh_pkg::*;
#(
  parameter int NUM_CH    = 10,
  parameter int DIV_HALF  = 2381,
  parameter bit DRIVE_PIN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         extSel,
  input  logic         extClkIn,
  output refresh_ctl_t ctl,
  output logic         oscOut,
  output logic         oscOe
);
  localparam int DIV_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_HALF - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_CH - 1);

  logic [DIV_W-1:0]  divCnt;
  logic              intOsc;
  logic              divWrap;
  logic              intFall;
  logic              extMeta, extSync, extPrev;
  logic              extFall;
  logic              tickNow;
  logic [SLOT_W-1:0] slotPtr;

  // internal divider: intOsc toggles every DIV_HALF cycles
  assign divWrap = (divCnt == DIV_LAST);
  assign intFall = divWrap && intOsc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divCnt <= '0;
      intOsc <= 1'b0;
    end else if (divWrap) begin
      divCnt <= '0;
      intOsc <= ~intOsc;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // external clock: two-stage synchroniser plus falling-edge detect
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      extMeta <= 1'b0;
      extSync <= 1'b0;
      extPrev <= 1'b0;
    end else begin
      extMeta <= extClkIn;
      extSync <= extMeta;
      extPrev <= extSync;
    end
  end

  assign extFall = extPrev && !extSync;
  assign tickNow = extSel ? extFall : intFall;

  // channel rotation and strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slotPtr  <= '0;
      ctl.load <= 1'b0;
      ctl.slot <= '0;
    end else begin
      ctl.load <= tickNow;
      if (tickNow) begin
        ctl.slot <= slotPtr;
        slotPtr  <= (slotPtr == SLOT_LAST) ? '0 : slotPtr + 1'b1;
      end
    end
  end

  // shared pin driver: off in reset and in external mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oscOe <= 1'b0;
    else        oscOe <= DRIVE_PIN && !extSel;
  end

  assign oscOut = intOsc;
endmodule

// File: rtl/refresh_datapath.sv
module refresh_datapath
  import refresh_pkg::*;
#(
  parameter int NUM_CH   = 10,
  parameter int CODE_W   = 10,
  parameter int MAX_STEP = 136
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  refresh_ctl_t             ctl,
  input  logic [NUM_CH*CODE_W-1:0] targetCodes,
  output logic [NUM_CH*CODE_W-1:0] appliedCodes
);
  localparam int WIDE = CODE_W + 1;
  localparam logic [WIDE-1:0] STEP_W = WIDE'(MAX_STEP);

  function automatic logic [CODE_W-1:0] stepToward(input logic [CODE_W-1:0] cur,
                                                   input logic [CODE_W-1:0] tgt);
    logic [WIDE-1:0] c, t;
    c = {1'b0, cur};
    t = {1'b0, tgt};
    if (t >= c) begin
      if ((t - c) <= STEP_W) return tgt;
      return CODE_W'(c + STEP_W);
    end
    if ((c - t) <= STEP_W) return tgt;
    return CODE_W'(c - STEP_W);
  endfunction

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [CODE_W-1:0] curCode;
    logic [CODE_W-1:0] nextCode;
    logic              visit;

    assign visit    = ctl.load && (ctl.slot == SLOT_W'(ch));
    assign nextCode = stepToward(curCode, targetCodes[ch*CODE_W +: CODE_W]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     curCode <= '0;
      else if (visit) curCode <= nextCode;
    end

    assign appliedCodes[ch*CODE_W +: CODE_W] = curCode;
  end
endmodule

// File: rtl/gamma_refresh_seq.sv
module gamma_refresh_seq
  import refresh_pkg::*;
#(
  parameter int NUM_CH    = 10,
  parameter int CODE_W    = 10,
  parameter int MAX_STEP  = 136,
  parameter int DIV_HALF  = 2381,
  parameter bit DRIVE_PIN = 1'b1,
  localparam int IDX_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     extSel,
  input  logic                     extClkIn,
  input  logic [NUM_CH*CODE_W-1:0] targetCodes,
  output logic [NUM_CH*CODE_W-1:0] appliedCodes,
  output logic                     refreshStrobe,
  output logic [IDX_W-1:0]         refreshIdx,
  output logic                     oscOut,
  output logic                     oscOe
);
  refresh_ctl_t ctl;

  refresh_ctrl #(
    .NUM_CH(NUM_CH), .DIV_HALF(DIV_HALF), .DRIVE_PIN(DRIVE_PIN)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .extSel(extSel), .extClkIn(extClkIn),
    .ctl(ctl), .oscOut(oscOut), .oscOe(oscOe)
  );

  refresh_datapath #(
    .NUM_CH(NUM_CH), .CODE_W(CODE_W), .MAX_STEP(MAX_STEP)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl),
    .targetCodes(targetCodes), .appliedCodes(appliedCodes)
  );

  assign refreshStrobe = ctl.load;
  assign refreshIdx    = ctl.slot[IDX_W-1:0];
endmodule

// File: rtl/refresh_seq_chk.sv
module refresh_seq_chk #(
  parameter int NUM_CH   = 10,
  parameter int CODE_W   = 10,
  parameter int MAX_STEP = 136,
  parameter int IDX_W    = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     extSel,
  input logic                     refreshStrobe,
  input logic [IDX_W-1:0]         refreshIdx,
  input logic                     oscOe,
  input logic [NUM_CH*CODE_W-1:0] appliedCodes
);
  logic [IDX_W-1:0] expIdx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) expIdx <= '0;
    else if (refreshStrobe)
      expIdx <= (expIdx == IDX_W'(NUM_CH - 1)) ? '0 : expIdx + 1'b1;
  end

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    refreshStrobe |=> !refreshStrobe); // R4

  AST_IDX_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    refreshStrobe |-> (refreshIdx == expIdx)); // R3

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    refreshIdx < IDX_W'(NUM_CH)); // R3

  AST_OE_EXT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    extSel |=> !oscOe); // R9

  AST_HOLD_NO_VISIT: assert property (@(posedge clk) disable iff (!rst_n)
    !refreshStrobe |=> $stable(appliedCodes)); // R5

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_step
    logic [CODE_W-1:0] prevCode;
    logic [CODE_W-1:0] nowCode;
    logic [CODE_W:0]   delta;

    assign nowCode = appliedCodes[ch*CODE_W +: CODE_W];
    assign delta   = (nowCode >= prevCode) ? {1'b0, nowCode - prevCode}
                                           : {1'b0, prevCode - nowCode};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prevCode <= '0;
      else        prevCode <= nowCode;
    end

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      delta <= (CODE_W + 1)'(MAX_STEP)); // R7
  end
endmodule

bind gamma_refresh_seq refresh_seq_chk #(
  .NUM_CH(NUM_CH), .CODE_W(CODE_W), .MAX_STEP(MAX_STEP), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .extSel(extSel), .refreshStrobe(refreshStrobe),
  .refreshIdx(refreshIdx), .oscOe(oscOe), .appliedCodes(appliedCodes)
);

// File: tb/gamma_refresh_seq_tb.sv
module gamma_refresh_seq_tb;
  localparam int NUM_CH   = 5;
  localparam int CODE_W   = 10;
  localparam int MAX_STEP = 200;
  localparam int DIV_HALF = 8;
  localparam int IDX_W    = $clog2(NUM_CH);

  logic                     clk = 1'b0;
  logic                     rst_n;
  logic                     extSel;
  logic                     extClkIn;
  logic [NUM_CH*CODE_W-1:0] targetCodes;
  logic [NUM_CH*CODE_W-1:0] appliedCodes;
  logic                     refreshStrobe;
  logic [IDX_W-1:0]         refreshIdx;
  logic                     oscOut;
  logic                     oscOe;

  always #2.5 clk = ~clk;

  gamma_refresh_seq #(
    .NUM_CH(NUM_CH), .CODE_W(CODE_W), .MAX_STEP(MAX_STEP),
    .DIV_HALF(DIV_HALF), .DRIVE_PIN(1'b1)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .extSel(extSel), .extClkIn(extClkIn),
    .targetCodes(targetCodes), .appliedCodes(appliedCodes),
    .refreshStrobe(refreshStrobe), .refreshIdx(refreshIdx),
    .oscOut(oscOut), .oscOe(oscOe)
  );

  int checks = 0;
  int errors = 0;
  int model [NUM_CH];
  int tgt   [NUM_CH];
  int cycleCnt = 0;
  int lastStrobeCyc = 0;
  bit lastValid = 0;
  bit intMode = 1;
  bit prevStrobe = 0;
  int expIdx = 0;
  int strobeCnt = 0;
  bit pendValid = 0;
  int pendCh = 0;
  bit pendNear = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic int stepTo(input int c, input int t);
    if (t >= c) return (t - c <= MAX_STEP) ? t : c + MAX_STEP;
    return (c - t <= MAX_STEP) ? t : c - MAX_STEP;
  endfunction

  function automatic int applied(input int ch);
    return int'(appliedCodes[ch*CODE_W +: CODE_W]);
  endfunction

  // one system cycle, sampled at the falling clock edge
  task automatic tick1();
    int d;
    @(negedge clk);
    cycleCnt++;
    if (pendValid) begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        if (ch == pendCh)
          check(applied(ch) == model[ch], pendNear ? "R6" : "R7", applied(ch), model[ch]);
        else
          check(applied(ch) == model[ch], "R5", applied(ch), model[ch]);
      end
      pendValid = 0;
    end
    if (prevStrobe && refreshStrobe) check(1'b0, "R4 strobe wider than one cycle", 1, 0);
    if (refreshStrobe) begin
      strobeCnt++;
      check(int'(refreshIdx) == expIdx, "R3", int'(refreshIdx), expIdx);
      if (intMode && lastValid)
        check(cycleCnt - lastStrobeCyc == 2 * DIV_HALF, "R2",
              cycleCnt - lastStrobeCyc, 2 * DIV_HALF);
      lastStrobeCyc = cycleCnt;
      lastValid = 1;
      expIdx = (expIdx + 1) % NUM_CH;
      pendCh = int'(refreshIdx);
      d = tgt[pendCh] - model[pendCh];
      if (d < 0) d = -d;
      pendNear = (d <= MAX_STEP);
      model[pendCh] = stepTo(model[pendCh], tgt[pendCh]);
      pendValid = 1;
    end
    prevStrobe = refreshStrobe;
  endtask

  task automatic runCycles(input int n);
    for (int i = 0; i < n; i++) tick1();
  endtask

  task automatic setTargets(input int v0, input int v1, input int v2, input int v3, input int v4);
    int v [NUM_CH];
    while (pendValid || refreshStrobe) tick1();
    v = '{v0, v1, v2, v3, v4};
    for (int ch = 0; ch < NUM_CH; ch++) begin
      tgt[ch] = v[ch];
      targetCodes[ch*CODE_W +: CODE_W] = CODE_W'(v[ch]);
    end
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    extSel = 1'b0;
    extClkIn = 1'b1;
    targetCodes = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      model[ch] = 0;
      tgt[ch] = 0;
    end
    repeat (4) @(negedge clk);
    for (int ch = 0; ch < NUM_CH; ch++) check(applied(ch) == 0, "R1 applied", applied(ch), 0);
    check(refreshStrobe == 1'b0, "R1 strobe", int'(refreshStrobe), 0);
    check(oscOe == 1'b0, "R1 pin enable", int'(oscOe), 0);
    rst_n = 1'b1;
    runCycles(2);
    check(oscOe == 1'b1, "R9 enable in internal mode", int'(oscOe), 1);
  endtask

  task automatic t_internal_small();
    setTargets(50, 120, 200, 7, 0);
    runCycles(2 * NUM_CH * 2 * DIV_HALF + 4);
    setTargets(10, 300, 150, 0, 199);
    runCycles(NUM_CH * 2 * DIV_HALF + 4);
  endtask

  task automatic t_large_swing();
    setTargets(1023, 1023, 600, 1023, 512);
    runCycles(7 * NUM_CH * 2 * DIV_HALF);
    for (int ch = 0; ch < NUM_CH; ch++) check(applied(ch) == tgt[ch], "R7 settled up", applied(ch), tgt[ch]);
    setTargets(0, 5, 0, 900, 0);
    runCycles(7 * NUM_CH * 2 * DIV_HALF);
    for (int ch = 0; ch < NUM_CH; ch++) check(applied(ch) == tgt[ch], "R7 settled down", applied(ch), tgt[ch]);
  endtask

  task automatic t_external();
    int base;
    int c0;
    int t0;
    setTargets(400, 30, 1000, 250, 800);
    extClkIn = 1'b1;
    extSel = 1'b1;
    intMode = 0;
    lastValid = 0;
    runCycles(2);
    check(oscOe == 1'b0, "R9 off in external mode", int'(oscOe), 0);
    base = strobeCnt;
    runCycles(6 * DIV_HALF);
    check(strobeCnt == base, "R8 no strobe while input steady", strobeCnt - base, 0);
    for (int k = 0; k < 6; k++) begin
      extClkIn = 1'b0;
      c0 = cycleCnt;
      base = strobeCnt;
      runCycles(3);
      check(lastStrobeCyc == c0 + 3 && strobeCnt == base + 1, "R8 edge latency",
            lastStrobeCyc - c0, 3);
      runCycles(5);
      extClkIn = 1'b1;
      base = strobeCnt;
      runCycles(8);
      check(strobeCnt == base, "R8 no strobe on rising edge", strobeCnt - base, 0);
    end
    extSel = 1'b0;
    intMode = 1;
    lastValid = 0;
    runCycles(2);
    check(oscOe == 1'b1, "R9 enable back in internal mode", int'(oscOe), 1);
    t0 = int'(oscOut);
    runCycles(DIV_HALF + 1);
    check(int'(oscOut) != t0, "R9 pin clock toggles", int'(oscOut), 1 - t0);
    runCycles(3 * NUM_CH * 2 * DIV_HALF);
  endtask

  initial begin
    t_reset_state();
    t_internal_small();
    t_large_swing();
    t_external();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule